// File: doc/BRIEF.md
# External-Memory Ring Buffer FIFO Controller

This block turns a window of external memory into a byte-wide first-in first-out queue. Software places the window with a base address and a size in bytes. A producer posts a write command carrying a byte count and then streams that many bytes. A consumer posts a read command carrying a byte count and receives that many bytes, oldest first.

The controller never lets a memory burst exceed 64 bytes or run past the end of the window. It keeps one position counter per direction and a shared fill level. It moves the data through one memory-access port that uses a level request and a one-cycle done pulse. Data bytes pass straight between the host streams and the memory port while a burst of the matching direction owns the port.

When a command cannot proceed because the queue is too full or too empty, it waits rather than discarding data. Each such wait is counted once. Status outputs report the fill level, the free space, the window size and the two wait counters.

Top module: `xring_fifo`

## Requirements
- R1: Each burst length equals the smallest of the bytes still owed to the current command, 64, and the window size minus the current position of that direction. A burst is never zero bytes long and never extends past the last byte of the window.
- R2: The burst address is the base address plus the position of the issuing direction. Request, address, length and direction stay constant until done.
- R3: A write burst starts only when the free space is at least its length. Otherwise the write side waits and the overflow counter rises.
- R4: A read burst starts only when the fill level is at least its length. Otherwise the read side waits and the underrun counter rises.
- R5: When a burst completes, the position of its direction advances by the burst length and returns to 0 on reaching the window size. In the same clock edge the fill level rises (write) or falls (read) by that length, and at no other time.
- R6: stat_fill is the byte count held, stat_free equals the window size minus stat_fill, and stat_total equals the window size.
- R7: A waiting side adds exactly 1 to its counter per wait episode, however long the wait lasts. The counters saturate at all ones.
- R8: When both sides are ready to issue in the same cycle, the port grants the direction opposite to the previous grant.
- R9: Synchronous active-high reset clears both positions, the fill level and both counters, and leaves both command inputs ready.
- R10: A command with length 0 raises its done output in the cycle right after acceptance and causes no memory burst.
- R11: Read data bytes come out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base | input | AW | Base byte address of the window |
| cfg_size | input | LW | Window size in bytes, held stable while in use |
| wr_cmd_valid | input | 1 | Write command offered |
| wr_cmd_len | input | LW | Write command byte count |
| wr_cmd_ready | output | 1 | Write side idle, command accepted when valid |
| wr_cmd_done | output | 1 | One-cycle pulse, write command finished |
| wr_data_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_data_ready | output | 1 | Write byte taken this cycle |
| rd_cmd_valid | input | 1 | Read command offered |
| rd_cmd_len | input | LW | Read command byte count |
| rd_cmd_ready | output | 1 | Read side idle, command accepted when valid |
| rd_cmd_done | output | 1 | One-cycle pulse, read command finished |
| rd_data_valid | output | 1 | Read byte present, consumer must take it |
| rd_data | output | 8 | Read byte |
| mem_req | output | 1 | Burst request, held until mem_done |
| mem_we | output | 1 | Burst direction, 1 write, 0 read |
| mem_addr | output | AW | Burst start byte address |
| mem_len | output | BW | Burst length in bytes |
| mem_done | input | 1 | One-cycle pulse, burst finished |
| mem_wvalid | output | 1 | Write byte toward memory |
| mem_wdata | output | 8 | Write byte value |
| mem_wready | input | 1 | Memory takes write byte |
| mem_rvalid | input | 1 | Read byte from memory |
| mem_rdata | input | 8 | Read byte value |
| stat_fill | output | LW | Bytes held |
| stat_free | output | LW | Bytes free |
| stat_total | output | LW | Window size |
| stat_overflow | output | CW | Write wait episodes |
| stat_underrun | output | CW | Read wait episodes |

## Verification
Two kinds of same-cycle collision matter here. The first occurs when both directions want the single port in the same cycle. The bench provokes it by accepting a write and a read command on the same edge while the queue holds enough data and space for both. It then expects the first burst to go to the direction that was not granted last, and the second burst to the other direction. The second collision occurs when a burst completes on the edge where the waiting opposite side re-evaluates its room. The stall tests provoke it and then check that each waiting side's counter reads exactly 1 and that the delayed burst follows with the correct address, length and data.

// File: rtl/xring_pkg.sv
package xring_pkg;

    localparam int unsigned SIDE_RD   = 0;
    localparam int unsigned SIDE_WR   = 1;
    localparam int unsigned NUM_SIDES = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_BUSY = 2'd2
    } side_st_e;

    function automatic logic [31:0] min3(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input logic [31:0] c);
        logic [31:0] m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/xring_side.sv
module xring_side
    import xring_pkg::*;
#(
    parameter int unsigned LW    = 16,
    parameter int unsigned BW    = 7,
    parameter int unsigned CW    = 16,
    parameter int unsigned MAXB  = 64,
    parameter bit          IS_WR = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [LW-1:0] cmd_len,
    output logic          cmd_ready,
    output logic          cmd_done,
    input  logic [LW-1:0] cfg_size,
    input  logic [LW-1:0] fill,
    input  logic          grant,
    input  logic          burst_done,
    output logic          want,
    output logic [BW-1:0] blen,
    output logic [LW-1:0] pos,
    output logic [CW-1:0] stall_cnt
);

    side_st_e      st_q;
    logic [LW-1:0] rem_q;
    logic [LW-1:0] pos_q;
    logic [CW-1:0] cnt_q;
    logic          stalled_q;
    logic          done_q;

    logic [LW-1:0] to_end;
    logic [LW-1:0] avail;
    logic [31:0]   len32;
    logic [LW-1:0] pos_next;
    logic          fits;
    logic          blocked;

    always_comb begin
        to_end  = cfg_size - pos_q;
        len32   = min3(32'(rem_q), 32'(MAXB), 32'(to_end));
        avail   = IS_WR ? (cfg_size - fill) : fill;
        fits    = 32'(avail) >= len32;
        blocked = (st_q == ST_RUN) && !fits;
        pos_next = pos_q + LW'(len32);
        if (pos_next >= cfg_size) begin
            pos_next = '0;
        end
    end

    assign blen      = BW'(len32);
    assign want      = (st_q == ST_RUN) && fits;
    assign cmd_ready = (st_q == ST_IDLE);
    assign cmd_done  = done_q;
    assign pos       = pos_q;
    assign stall_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            rem_q     <= '0;
            pos_q     <= '0;
            cnt_q     <= '0;
            stalled_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            rem_q <= cmd_len;
                            st_q  <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (grant) begin
                        st_q <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (burst_done) begin
                        rem_q <= rem_q - LW'(len32);
                        pos_q <= pos_next;
                        if (32'(rem_q) == len32) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            st_q <= ST_RUN;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase

            if (blocked && !stalled_q) begin
                stalled_q <= 1'b1;
                if (cnt_q != {CW{1'b1}}) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (!blocked) begin
                stalled_q <= 1'b0;
            end
        end
    end

    // R7: a continuing wait leaves the counter untouched
    p_stall_once_r7: assert property (@(posedge clk) disable iff (rst)
        blocked && stalled_q |=> $stable(cnt_q));

    // R10: empty command finishes on the next edge without leaving idle
    p_zero_len_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) && cmd_valid && (cmd_len == '0) |=> cmd_done && (st_q == ST_IDLE));

    // R5: a position always lies inside the window
    p_pos_range_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_size != '0) |-> (pos_q < cfg_size));

endmodule

// File: rtl/xring_port.sv
module xring_port
    import xring_pkg::*;
#(
    parameter int unsigned AW = 24,
    parameter int unsigned LW = 16,
    parameter int unsigned BW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    want,
    input  logic [BW-1:0] rd_blen,
    input  logic [BW-1:0] wr_blen,
    input  logic [LW-1:0] rd_pos,
    input  logic [LW-1:0] wr_pos,
    input  logic [AW-1:0] cfg_base,
    input  logic          mem_done,
    output logic [1:0]    grant,
    output logic [1:0]    side_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [BW-1:0] mem_len
);

    logic          busy_q;
    logic          we_q;
    logic          last_wr_q;
    logic [AW-1:0] addr_q;
    logic [BW-1:0] len_q;
    logic          pick_wr;
    logic          start;

    always_comb begin
        pick_wr = want[SIDE_WR] && (!want[SIDE_RD] || !last_wr_q);
        start   = !busy_q && (|want);
        grant   = '0;
        if (start) begin
            grant[SIDE_WR] = pick_wr;
            grant[SIDE_RD] = !pick_wr;
        end
        side_done = '0;
        if (busy_q && mem_done) begin
            side_done[SIDE_WR] = we_q;
            side_done[SIDE_RD] = !we_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            we_q      <= 1'b0;
            last_wr_q <= 1'b0;
            addr_q    <= '0;
            len_q     <= '0;
        end else if (start) begin
            busy_q    <= 1'b1;
            we_q      <= pick_wr;
            last_wr_q <= pick_wr;
            addr_q    <= cfg_base + AW'(pick_wr ? wr_pos : rd_pos);
            len_q     <= pick_wr ? wr_blen : rd_blen;
        end else if (busy_q && mem_done) begin
            busy_q <= 1'b0;
        end
    end

    assign mem_req  = busy_q;
    assign mem_we   = we_q;
    assign mem_addr = addr_q;
    assign mem_len  = len_q;

    // R2: burst descriptor frozen until completion
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_done |=> mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_we));

    // R8: a tie goes to the direction not served last
    p_alternate_r8: assert property (@(posedge clk) disable iff (rst)
        !busy_q && (want == 2'b11) |=> mem_req && (mem_we != $past(last_wr_q)));

endmodule

// File: rtl/xring_level.sv
module xring_level #(
    parameter int unsigned LW = 16,
    parameter int unsigned BW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] cfg_size,
    input  logic          wr_done,
    input  logic          rd_done,
    input  logic [BW-1:0] wr_len,
    input  logic [BW-1:0] rd_len,
    output logic [LW-1:0] fill,
    output logic [LW-1:0] free
);

    logic [LW-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (wr_done) begin
            fill_q <= fill_q + LW'(wr_len);
        end else if (rd_done) begin
            fill_q <= fill_q - LW'(rd_len);
        end
    end

    assign fill = fill_q;
    assign free = cfg_size - fill_q;

    // R6: never more bytes held than the window size
    p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
        fill_q <= cfg_size);

    // R5: the level moves only on a burst completion
    p_fill_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_done && !rd_done |=> $stable(fill_q));

    // R5: one completion at a time
    p_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_done && rd_done));

endmodule

// File: rtl/xring_fifo.sv
module xring_fifo
    import xring_pkg::*;
#(
    parameter int unsigned AW   = 24,
    parameter int unsigned LW   = 16,
    parameter int unsigned CW   = 16,
    parameter int unsigned MAXB = 64,
    localparam int unsigned BW  = $clog2(MAXB + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_size,
    input  logic          wr_cmd_valid,
    input  logic [LW-1:0] wr_cmd_len,
    output logic          wr_cmd_ready,
    output logic          wr_cmd_done,
    input  logic          wr_data_valid,
    input  logic [7:0]    wr_data,
    output logic          wr_data_ready,
    input  logic          rd_cmd_valid,
    input  logic [LW-1:0] rd_cmd_len,
    output logic          rd_cmd_ready,
    output logic          rd_cmd_done,
    output logic          rd_data_valid,
    output logic [7:0]    rd_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [BW-1:0] mem_len,
    input  logic          mem_done,
    output logic          mem_wvalid,
    output logic [7:0]    mem_wdata,
    input  logic          mem_wready,
    input  logic          mem_rvalid,
    input  logic [7:0]    mem_rdata,
    output logic [LW-1:0] stat_fill,
    output logic [LW-1:0] stat_free,
    output logic [LW-1:0] stat_total,
    output logic [CW-1:0] stat_overflow,
    output logic [CW-1:0] stat_underrun
);

    logic [1:0]    cmd_valid;
    logic [1:0]    cmd_ready;
    logic [1:0]    cmd_done;
    logic [1:0]    want;
    logic [1:0]    grant;
    logic [1:0]    side_done;
    logic [LW-1:0] cmd_len [NUM_SIDES];
    logic [LW-1:0] pos     [NUM_SIDES];
    logic [BW-1:0] blen    [NUM_SIDES];
    logic [CW-1:0] scnt    [NUM_SIDES];
    logic          wr_owns;
    logic          rd_owns;

    assign cmd_valid[SIDE_WR] = wr_cmd_valid;
    assign cmd_valid[SIDE_RD] = rd_cmd_valid;
    assign cmd_len[SIDE_WR]   = wr_cmd_len;
    assign cmd_len[SIDE_RD]   = rd_cmd_len;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        xring_side #(
            .LW    (LW),
            .BW    (BW),
            .CW    (CW),
            .MAXB  (MAXB),
            .IS_WR (s == SIDE_WR)
        ) i_side (
            .clk        (clk),
            .rst        (rst),
            .cmd_valid  (cmd_valid[s]),
            .cmd_len    (cmd_len[s]),
            .cmd_ready  (cmd_ready[s]),
            .cmd_done   (cmd_done[s]),
            .cfg_size   (cfg_size),
            .fill       (stat_fill),
            .grant      (grant[s]),
            .burst_done (side_done[s]),
            .want       (want[s]),
            .blen       (blen[s]),
            .pos        (pos[s]),
            .stall_cnt  (scnt[s])
        );
    end

    xring_port #(
        .AW (AW),
        .LW (LW),
        .BW (BW)
    ) i_port (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .rd_blen   (blen[SIDE_RD]),
        .wr_blen   (blen[SIDE_WR]),
        .rd_pos    (pos[SIDE_RD]),
        .wr_pos    (pos[SIDE_WR]),
        .cfg_base  (cfg_base),
        .mem_done  (mem_done),
        .grant     (grant),
        .side_done (side_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_len   (mem_len)
    );

    xring_level #(
        .LW (LW),
        .BW (BW)
    ) i_level (
        .clk      (clk),
        .rst      (rst),
        .cfg_size (cfg_size),
        .wr_done  (side_done[SIDE_WR]),
        .rd_done  (side_done[SIDE_RD]),
        .wr_len   (blen[SIDE_WR]),
        .rd_len   (blen[SIDE_RD]),
        .fill     (stat_fill),
        .free     (stat_free)
    );

    assign wr_owns       = mem_req && mem_we;
    assign rd_owns       = mem_req && !mem_we;
    assign mem_wvalid    = wr_data_valid && wr_owns;
    assign mem_wdata     = wr_data;
    assign wr_data_ready = mem_wready && wr_owns;
    assign rd_data_valid = mem_rvalid && rd_owns;
    assign rd_data       = mem_rdata;

    assign wr_cmd_ready  = cmd_ready[SIDE_WR];
    assign rd_cmd_ready  = cmd_ready[SIDE_RD];
    assign wr_cmd_done   = cmd_done[SIDE_WR];
    assign rd_cmd_done   = cmd_done[SIDE_RD];
    assign stat_total    = cfg_size;
    assign stat_overflow = scnt[SIDE_WR];
    assign stat_underrun = scnt[SIDE_RD];

    // R1: burst length bounded and non-zero
    p_len_cap_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_len != '0) && (32'(mem_len) <= MAXB));

    // R1: burst never runs past the window end
    p_no_cross_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (32'(AW'(mem_addr - cfg_base)) + 32'(mem_len) <= 32'(cfg_size)));

    // R3: a write burst starts only with room for it
    p_write_room_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && mem_we |-> (32'(stat_free) >= 32'(mem_len)));

    // R4: a read burst starts only with enough data held
    p_read_data_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && !mem_we |-> (32'(stat_fill) >= 32'(mem_len)));

endmodule

// File: tb/test_xring_fifo.sv
module test_xring_fifo;

    localparam int unsigned AW   = 24;
    localparam int unsigned LW   = 16;
    localparam int unsigned CW   = 16;
    localparam int unsigned MAXB = 64;
    localparam int unsigned BW   = $clog2(MAXB + 1);
    localparam int          SIZE = 200;
    localparam logic [AW-1:0] BASE = 24'h000100;
    localparam int          NVEC = 8;
    // {is_write, length}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 16'd100}, {1'b0, 16'd30}, {1'b1, 16'd90}, {1'b0, 16'd150},
        {1'b1, 16'd64},  {1'b0, 16'd74}, {1'b1, 16'd0},  {1'b0, 16'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_base = BASE;
    logic [LW-1:0] cfg_size = LW'(SIZE);
    logic          wr_cmd_valid = 1'b0;
    logic [LW-1:0] wr_cmd_len = '0;
    logic          wr_cmd_ready, wr_cmd_done;
    logic          wr_data_valid = 1'b1;
    logic [7:0]    wr_data;
    logic          wr_data_ready;
    logic          rd_cmd_valid = 1'b0;
    logic [LW-1:0] rd_cmd_len = '0;
    logic          rd_cmd_ready, rd_cmd_done;
    logic          rd_data_valid;
    logic [7:0]    rd_data;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_len;
    logic          mem_done;
    logic          mem_wvalid;
    logic [7:0]    mem_wdata;
    logic          mem_wready;
    logic          mem_rvalid;
    logic [7:0]    mem_rdata;
    logic [LW-1:0] stat_fill, stat_free, stat_total;
    logic [CW-1:0] stat_overflow, stat_underrun;

    always #2 clk = ~clk;

    xring_fifo #(.AW(AW), .LW(LW), .CW(CW), .MAXB(MAXB)) i_xring_fifo (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_len(wr_cmd_len),
        .wr_cmd_ready(wr_cmd_ready), .wr_cmd_done(wr_cmd_done),
        .wr_data_valid(wr_data_valid), .wr_data(wr_data), .wr_data_ready(wr_data_ready),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_len(rd_cmd_len),
        .rd_cmd_ready(rd_cmd_ready), .rd_cmd_done(rd_cmd_done),
        .rd_data_valid(rd_data_valid), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_done(mem_done), .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata),
        .mem_wready(mem_wready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .stat_fill(stat_fill), .stat_free(stat_free), .stat_total(stat_total),
        .stat_overflow(stat_overflow), .stat_underrun(stat_underrun)
    );

    int errors = 0;
    int checks = 0;
    int wr_n = 0;
    int rd_n = 0;
    int wr_dones = 0;
    int rd_dones = 0;
    int bursts = 0;
    int ref_pos [2];
    int ref_rem [2];
    int ref_fill = 0;
    logic seq_we [4];
    int seq_n = 0;
    bit seq_on = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int n);
        return 8'((n * 7 + 3) & 255);
    endfunction

    assign wr_data = pat(wr_n);

    // memory model
    logic [7:0]    mem [512];
    logic          m_busy = 1'b0;
    logic          m_done = 1'b0;
    logic          m_we = 1'b0;
    logic [AW-1:0] m_addr = '0;
    int            m_len = 0;
    int            m_cnt = 0;

    assign mem_wready = m_busy && m_we;
    assign mem_rvalid = m_busy && !m_we;
    assign mem_rdata  = mem[9'(m_addr + AW'(m_cnt))];
    assign mem_done   = m_done;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy && !m_done && mem_req) begin
                automatic int s = mem_we ? 1 : 0;
                automatic int e = ref_rem[s];
                if (e > MAXB) e = MAXB;
                if (e > SIZE - ref_pos[s]) e = SIZE - ref_pos[s];
                chk(int'(mem_len) == e, "R1 burst length", int'(mem_len), e);
                chk(mem_addr == BASE + AW'(ref_pos[s]), "R2 burst address",
                    int'(mem_addr), int'(BASE) + ref_pos[s]);
                ref_pos[s] = ref_pos[s] + int'(mem_len);
                if (ref_pos[s] >= SIZE) ref_pos[s] = 0;
                ref_rem[s] = ref_rem[s] - int'(mem_len);
                ref_fill = mem_we ? ref_fill + int'(mem_len) : ref_fill - int'(mem_len);
                bursts++;
                if (seq_on && seq_n < 4) begin
                    seq_we[seq_n] = mem_we;
                    seq_n++;
                end
                m_busy <= 1'b1;
                m_we   <= mem_we;
                m_addr <= mem_addr;
                m_len  <= int'(mem_len);
                m_cnt  <= 0;
            end else if (m_busy) begin
                if (!m_we || mem_wvalid) begin
                    if (m_we) mem[9'(m_addr + AW'(m_cnt))] <= mem_wdata;
                    m_cnt <= m_cnt + 1;
                    if (m_cnt + 1 == m_len) begin
                        m_busy <= 1'b0;
                        m_done <= 1'b1;
                    end
                end
            end
        end
    end

    // host stream observers
    always @(posedge clk) begin
        if (!rst) begin
            if (wr_data_valid && wr_data_ready) wr_n <= wr_n + 1;
            if (rd_data_valid) begin
                chk(rd_data == pat(rd_n), "R11 read byte order", int'(rd_data), int'(pat(rd_n)));
                rd_n <= rd_n + 1;
            end
            if (wr_cmd_done) wr_dones <= wr_dones + 1;
            if (rd_cmd_done) rd_dones <= rd_dones + 1;
        end
    end

    task automatic issue(input bit is_wr, input int len);
        @(negedge clk);
        if (is_wr) begin
            while (!wr_cmd_ready) @(negedge clk);
            wr_cmd_valid = 1'b1; wr_cmd_len = LW'(len); ref_rem[1] = len;
        end else begin
            while (!rd_cmd_ready) @(negedge clk);
            rd_cmd_valid = 1'b1; rd_cmd_len = LW'(len); ref_rem[0] = len;
        end
        @(negedge clk);
        wr_cmd_valid = 1'b0;
        rd_cmd_valid = 1'b0;
    endtask

    task automatic wait_dones(input int wt, input int rt);
        while (wr_dones < wt || rd_dones < rt) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_level(input string tag);
        chk(int'(stat_fill) == ref_fill, {tag, " fill level"}, int'(stat_fill), ref_fill);
        chk(int'(stat_free) == SIZE - ref_fill, "R6 free space", int'(stat_free), SIZE - ref_fill);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ref_pos[0] = 0; ref_pos[1] = 0; ref_rem[0] = 0; ref_rem[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(stat_fill == '0, "R9 fill after reset", int'(stat_fill), 0);
        chk(stat_overflow == '0 && stat_underrun == '0, "R9 counters after reset",
            int'(stat_overflow) + int'(stat_underrun), 0);
        chk(wr_cmd_ready && rd_cmd_ready, "R9 command ready", int'(wr_cmd_ready && rd_cmd_ready), 1);
        chk(int'(stat_total) == SIZE, "R6 total size", int'(stat_total), SIZE);
        chk(!mem_req, "R9 no request", int'(mem_req), 0);

        // vector walk
        for (int v = 0; v < NVEC; v++) begin
            automatic int b0 = bursts;
            automatic bit w = VEC[v][16];
            automatic int n = int'(VEC[v][15:0]);
            issue(w, n);
            if (w) wait_dones(wr_dones + 1, rd_dones);
            else   wait_dones(wr_dones, rd_dones + 1);
            check_level("R5");
            if (n == 0) chk(bursts == b0, "R10 zero length burst count", bursts - b0, 0);
        end
        chk(stat_overflow == '0 && stat_underrun == '0, "R7 no stalls in walk",
            int'(stat_overflow) + int'(stat_underrun), 0);

        // R10: done exactly one cycle after acceptance
        @(negedge clk);
        wr_cmd_valid = 1'b1; wr_cmd_len = '0;
        @(negedge clk);
        wr_cmd_valid = 1'b0;
        chk(wr_cmd_done, "R10 done one cycle after accept", int'(wr_cmd_done), 1);
        @(negedge clk);
        chk(!wr_cmd_done, "R10 single done pulse", int'(wr_cmd_done), 0);

        // R4 / R7: underrun wait
        begin
            automatic int b0 = bursts;
            automatic int wd = wr_dones;
            automatic int rdn = rd_dones;
            issue(1'b0, 10);
            repeat (12) @(negedge clk);
            chk(int'(stat_underrun) == 1, "R7 underrun counted once", int'(stat_underrun), 1);
            chk(bursts == b0, "R4 no read burst when empty", bursts - b0, 0);
            chk(!rd_cmd_ready, "R4 read still pending", int'(rd_cmd_ready), 0);
            issue(1'b1, 10);
            wait_dones(wd + 1, rdn + 1);
            chk(int'(stat_underrun) == 1, "R4 underrun after release", int'(stat_underrun), 1);
            check_level("R5");
        end

        // R3 / R7: overflow wait
        begin
            automatic int wd = wr_dones;
            automatic int rdn = rd_dones;
            issue(1'b1, SIZE);
            wait_dones(wd + 1, rdn);
            chk(int'(stat_fill) == SIZE, "R3 full window", int'(stat_fill), SIZE);
            issue(1'b1, 5);
            repeat (12) @(negedge clk);
            chk(int'(stat_overflow) == 1, "R7 overflow counted once", int'(stat_overflow), 1);
            chk(!wr_cmd_ready, "R3 write still pending", int'(wr_cmd_ready), 0);
            chk(int'(stat_free) == 0, "R3 free space zero", int'(stat_free), 0);
            issue(1'b0, 5);
            wait_dones(wd + 2, rdn + 1);
            chk(int'(stat_overflow) == 1, "R3 overflow after release", int'(stat_overflow), 1);
            check_level("R5");
            issue(1'b0, SIZE);
            wait_dones(wd + 2, rdn + 2);
            check_level("R5");
        end

        // R8: simultaneous write and read, last grant was a write
        begin
            automatic int wd = wr_dones;
            automatic int rdn = rd_dones;
            issue(1'b1, 100);
            wait_dones(wd + 1, rdn);
            seq_n = 0; seq_on = 1'b1;
            @(negedge clk);
            wr_cmd_valid = 1'b1; wr_cmd_len = 16'd64; ref_rem[1] = 64;
            rd_cmd_valid = 1'b1; rd_cmd_len = 16'd64; ref_rem[0] = 64;
            @(negedge clk);
            wr_cmd_valid = 1'b0; rd_cmd_valid = 1'b0;
            wait_dones(wd + 2, rdn + 1);
            seq_on = 1'b0;
            chk(seq_n >= 2 && seq_we[0] == 1'b0, "R8 tie grants read first", int'(seq_we[0]), 0);
            chk(seq_n >= 2 && seq_we[1] == 1'b1, "R8 then write", int'(seq_we[1]), 1);
            check_level("R5");
        end

        // R9: reset with data held and counters non-zero
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ref_pos[0] = 0; ref_pos[1] = 0; ref_fill = 0;
        rd_n = wr_n;
        @(negedge clk);
        chk(stat_fill == '0, "R9 fill cleared", int'(stat_fill), 0);
        chk(stat_overflow == '0 && stat_underrun == '0, "R9 counters cleared",
            int'(stat_overflow) + int'(stat_underrun), 0);
        begin
            automatic int wd = wr_dones;
            automatic int rdn = rd_dones;
            issue(1'b1, 20);
            issue(1'b0, 20);
            wait_dones(wd + 1, rdn + 1);
            check_level("R9");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule